// File: doc/BRIEF.md
# Word-to-Byte Bus Bridge with Wait-State Insertion

The bridge sits between a processor's 16-bit memory interface and two kinds of memory. Regions classed as internal, such as boot ROM and scratch-pad RAM, are reached over a full-width path. That path has no added latency. Every other address goes out over an 8-bit external bus. Each word access on the external bus becomes two byte transfers, and each byte is stretched by a fixed number of wait states. The processor is stalled through a ready line for the whole time the word is being serialised.

Addresses are classified by a parameterised table of base/mask regions. Each region is tagged internal or external. An address that matches no region goes to the external bus. During a read the even byte is captured into a holding register, and the assembled word is shown to the processor in the single cycle in which ready returns. During a write the upper half of the word leaves first, then the lower half, with one write pulse per byte.

Top module: `byte_lane_bridge`

## Requirements
- R1: After reset, with no request present, `cpuReady` is 1 and `extRdStrb`, `extWrStrb`, `extDataOe` and `intEn` are all 0.
- R2: An address belongs to region i when `(cpuAddr & MASK[i]) == BASE[i]`. The lowest-numbered matching region decides, and an address that matches no region is external. In the default table, 0x0000–0x1FFF and 0x8000–0x83FF are internal. 0x6000–0x7FFF and 0x8000–0x9FFF are external, and everything else is external.
- R3: An internal access completes in the cycle it is presented (`cpuReady` = 1). `intEn` = 1, `intAddr` equals `cpuAddr` and `intWData` equals `cpuWData`. On reads `cpuRData` equals `intRData`, and no external strobe is raised.
- R4: `cpuReady` is 0 in the very cycle an external request is first presented.
- R5: An external word access lasts 2·(WAIT_STATES+1) cycles, which is 6 with the default of 2 wait states per byte. `cpuReady` is 1 only in the last of them.
- R6: The even byte (`extAddr[0]` = 0) occupies the first WAIT_STATES+1 cycles and the odd byte (`extAddr[0]` = 1) the rest. `extAddr[15:1]` equals `cpuAddr[15:1]` throughout.
- R7: On a read, `extRData` is sampled in the last cycle of the even byte. In the final cycle `cpuRData` = {even byte, current odd byte}, with the even byte on bits [15:8].
- R8: On a write, `extWData` carries `cpuWData[15:8]` during the even byte and `cpuWData[7:0]` during the odd byte. `extWrStrb` is 1 for exactly one cycle per byte, the last cycle of that byte, and `extDataOe` is 1 throughout.
- R9: On an external read, `extRdStrb` is 1 in every cycle of both bytes and `extWrStrb` is 0. The two strobes are never 1 together.
- R10: A new request presented in the cycle after a completion is decoded at once, with no idle cycle between the two accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpuMemEn | input | 1 | Processor memory request |
| cpuWe | input | 1 | 1 = write, 0 = read |
| cpuAddr | input | 16 | Processor byte address |
| cpuWData | input | 16 | Processor write data |
| cpuRData | output | 16 | Read data to processor |
| cpuReady | output | 1 | Access completes at an edge where this is 1 |
| intEn | output | 1 | Internal region select |
| intWe | output | 1 | Internal write enable |
| intAddr | output | 16 | Internal address |
| intWData | output | 16 | Internal write data |
| intRData | input | 16 | Internal read data |
| extAddr | output | 16 | External address, bit 0 selects the byte |
| extWData | output | 8 | External write byte |
| extDataOe | output | 1 | External data drive enable |
| extRData | input | 8 | External read byte |
| extRdStrb | output | 1 | External read strobe |
| extWrStrb | output | 1 | External write pulse |

## Verification
Two functions meet at adjacent edges. One is the release of ready at the end of an external word. The other is the decoding of the next request, which may be internal and must then finish at once, or external and must drop ready in its first cycle. The bench provokes this by sweeping reads and writes over every 1 KB block of the address space, mostly back to back. Every cycle is judged against a count of expected cycles, expected byte-select and expected strobes worked out from the region ranges.

// File: rtl/blb_pkg.sv
package blb_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_EVEN = 2'd1,
    ST_ODD  = 2'd2
  } blb_state_e;

  // Control-to-datapath strobe bundle
  typedef struct packed {
    logic active;      // an external word transfer occupies this cycle
    logic oddByte;     // byte select for the external address
    logic rdStrb;      // external read strobe
    logic wrStrb;      // external write pulse
    logic holdEven;    // capture even byte into the holding register
    logic presentWord; // steer the assembled word to the processor
  } blb_strobe_t;

endpackage

// File: rtl/blb_region_decode.sv
module blb_region_decode #(
  parameter int ADDR_W      = 16,
  parameter int NUM_REGIONS = 4,
  parameter logic [ADDR_W-1:0] REGION_BASE [NUM_REGIONS] = '{16'h0000, 16'h8000, 16'h6000, 16'h8000},
  parameter logic [ADDR_W-1:0] REGION_MASK [NUM_REGIONS] = '{16'hE000, 16'hFC00, 16'hE000, 16'hE000},
  parameter logic [NUM_REGIONS-1:0] REGION_EXT = 4'b1100
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              isExt
);

  logic [NUM_REGIONS-1:0] matchVec;

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_match
    assign matchVec[g] = ((addr & REGION_MASK[g]) == REGION_BASE[g]);
  end

  // Lowest index wins: scan downward so the last write is the lowest match.
  always_comb begin
    isExt = 1'b1;
    for (int i = NUM_REGIONS - 1; i >= 0; i--) begin
      if (matchVec[i]) isExt = REGION_EXT[i];
    end
  end

endmodule

// File: rtl/blb_ctrl.sv
module blb_ctrl
  import blb_pkg::*;
#(
  parameter int WAIT_STATES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        extReq,
  input  logic        cpuWe,
  output blb_strobe_t strobes,
  output logic        cpuReady,
  output logic        busy
);

  localparam int CNT_W = (WAIT_STATES < 1) ? 1 : $clog2(WAIT_STATES + 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(WAIT_STATES);

  blb_state_e stateQ, stateD;
  logic [CNT_W-1:0] cntQ, cntD, curCnt;
  logic active, oddPhase, byteDone;

  always_comb begin
    curCnt   = (stateQ == ST_IDLE) ? '0 : cntQ;
    active   = (stateQ != ST_IDLE) || extReq;
    oddPhase = (stateQ == ST_ODD);
    byteDone = active && (curCnt == LAST_CNT);

    strobes.active      = active;
    strobes.oddByte     = oddPhase;
    strobes.rdStrb      = active && !cpuWe;
    strobes.wrStrb      = active && cpuWe && byteDone;
    strobes.holdEven    = active && !cpuWe && !oddPhase && byteDone;
    strobes.presentWord = oddPhase && byteDone;

    cpuReady = !active || (oddPhase && byteDone);
    busy     = (stateQ != ST_IDLE);

    stateD = stateQ;
    cntD   = cntQ;
    if (active) begin
      if (byteDone) begin
        cntD   = '0;
        stateD = oddPhase ? ST_IDLE : ST_ODD;
      end else begin
        cntD   = curCnt + 1'b1;
        stateD = oddPhase ? ST_ODD : ST_EVEN;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stateQ <= ST_IDLE;
      cntQ   <= '0;
    end else begin
      stateQ <= stateD;
      cntQ   <= cntD;
    end
  end

endmodule

// File: rtl/blb_dpath.sv
module blb_dpath
  import blb_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int BYTE_W = 8,
  localparam int WORD_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  blb_strobe_t       strobes,
  input  logic              cpuMemEn,
  input  logic              cpuWe,
  input  logic              isExt,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [WORD_W-1:0] cpuWData,
  output logic [WORD_W-1:0] cpuRData,
  output logic              intEn,
  output logic              intWe,
  output logic [ADDR_W-1:0] intAddr,
  output logic [WORD_W-1:0] intWData,
  input  logic [WORD_W-1:0] intRData,
  output logic [ADDR_W-1:0] extAddr,
  output logic [BYTE_W-1:0] extWData,
  output logic              extDataOe,
  input  logic [BYTE_W-1:0] extRData,
  output logic              extRdStrb,
  output logic              extWrStrb
);

  logic [BYTE_W-1:0] evenHoldQ;

  always_ff @(posedge clk) begin
    if (!rst_n)                evenHoldQ <= '0;
    else if (strobes.holdEven) evenHoldQ <= extRData;
  end

  always_comb begin
    intEn    = cpuMemEn && !isExt;
    intWe    = intEn && cpuWe;
    intAddr  = cpuAddr;
    intWData = cpuWData;

    extAddr   = {cpuAddr[ADDR_W-1:1], strobes.oddByte};
    extWData  = strobes.oddByte ? cpuWData[BYTE_W-1:0] : cpuWData[WORD_W-1:BYTE_W];
    extDataOe = strobes.active && cpuWe;
    extRdStrb = strobes.rdStrb;
    extWrStrb = strobes.wrStrb;

    cpuRData = strobes.presentWord ? {evenHoldQ, extRData} : intRData;
  end

endmodule

// File: rtl/byte_lane_bridge.sv
module byte_lane_bridge
  import blb_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int BYTE_W      = 8,
  parameter int WAIT_STATES = 2,
  parameter int NUM_REGIONS = 4,
  parameter logic [ADDR_W-1:0] REGION_BASE [NUM_REGIONS] = '{16'h0000, 16'h8000, 16'h6000, 16'h8000},
  parameter logic [ADDR_W-1:0] REGION_MASK [NUM_REGIONS] = '{16'hE000, 16'hFC00, 16'hE000, 16'hE000},
  parameter logic [NUM_REGIONS-1:0] REGION_EXT = 4'b1100,
  localparam int WORD_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpuMemEn,
  input  logic              cpuWe,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [WORD_W-1:0] cpuWData,
  output logic [WORD_W-1:0] cpuRData,
  output logic              cpuReady,
  output logic              intEn,
  output logic              intWe,
  output logic [ADDR_W-1:0] intAddr,
  output logic [WORD_W-1:0] intWData,
  input  logic [WORD_W-1:0] intRData,
  output logic [ADDR_W-1:0] extAddr,
  output logic [BYTE_W-1:0] extWData,
  output logic              extDataOe,
  input  logic [BYTE_W-1:0] extRData,
  output logic              extRdStrb,
  output logic              extWrStrb
);

  logic        isExt;
  logic        busy;
  blb_strobe_t strobes;

  blb_region_decode #(
    .ADDR_W(ADDR_W), .NUM_REGIONS(NUM_REGIONS),
    .REGION_BASE(REGION_BASE), .REGION_MASK(REGION_MASK), .REGION_EXT(REGION_EXT)
  ) decode_i (
    .addr(cpuAddr), .isExt(isExt)
  );

  blb_ctrl #(.WAIT_STATES(WAIT_STATES)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .extReq(cpuMemEn && isExt), .cpuWe(cpuWe),
    .strobes(strobes), .cpuReady(cpuReady), .busy(busy)
  );

  blb_dpath #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) dpath_i (
    .clk(clk), .rst_n(rst_n), .strobes(strobes), .cpuMemEn(cpuMemEn),
    .cpuWe(cpuWe), .isExt(isExt), .cpuAddr(cpuAddr), .cpuWData(cpuWData),
    .cpuRData(cpuRData), .intEn(intEn), .intWe(intWe), .intAddr(intAddr),
    .intWData(intWData), .intRData(intRData), .extAddr(extAddr),
    .extWData(extWData), .extDataOe(extDataOe), .extRData(extRData),
    .extRdStrb(extRdStrb), .extWrStrb(extWrStrb)
  );

endmodule

// File: rtl/blb_checker.sv
module blb_checker #(
  parameter int WAIT_STATES = 2
) (
  input logic clk,
  input logic rst_n,
  input logic cpuMemEn,
  input logic isExt,
  input logic busy,
  input logic cpuReady,
  input logic intEn,
  input logic extAddrLsb,
  input logic extRdStrb,
  input logic extWrStrb
);

  localparam logic [15:0] MAX_LOW = 16'(2 * WAIT_STATES + 1);
  localparam bit PULSE_CHECK = (WAIT_STATES > 0);

  logic [15:0] lowRun;

  always_ff @(posedge clk) begin
    if (!rst_n)                 lowRun <= '0;
    else if (cpuReady)          lowRun <= '0;
    else if (lowRun != 16'hFFFF) lowRun <= lowRun + 16'd1;
  end

  always @(posedge clk) begin
    if (rst_n) begin
      assert_low_run_R5: assert (cpuReady || lowRun < MAX_LOW)
        else $error("ready held low too long");
    end
  end

  assert_ready_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cpuMemEn && isExt && !busy) |-> !cpuReady);

  assert_internal_fast_R3: assert property (@(posedge clk) disable iff (!rst_n)
    intEn |-> (cpuReady && !extRdStrb && !extWrStrb));

  assert_write_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (PULSE_CHECK && extWrStrb) |=> !extWrStrb);

  assert_strobe_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(extRdStrb && extWrStrb));

  assert_finish_odd_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cpuReady && (extRdStrb || extWrStrb)) |-> extAddrLsb);

endmodule

bind byte_lane_bridge blb_checker #(.WAIT_STATES(WAIT_STATES)) chk_i (
  .clk(clk), .rst_n(rst_n), .cpuMemEn(cpuMemEn), .isExt(isExt), .busy(busy),
  .cpuReady(cpuReady), .intEn(intEn), .extAddrLsb(extAddr[0]),
  .extRdStrb(extRdStrb), .extWrStrb(extWrStrb)
);

// File: tb/byte_lane_bridge_tb_top.sv
module byte_lane_bridge_tb_top;

  localparam int W = 2;
  localparam int EXT_CYC = 2 * (W + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpuMemEn = 1'b0, cpuWe = 1'b0;
  logic [15:0] cpuAddr = '0, cpuWData = '0, cpuRData;
  logic cpuReady, intEn, intWe;
  logic [15:0] intAddr, intWData, intRData, extAddr;
  logic [7:0] extWData, extRData, salt = 8'h00;
  logic extDataOe, extRdStrb, extWrStrb;

  int checkCnt = 0, failCnt = 0;
  bit finished = 1'b0;

  logic [23:0] wrLog [2];
  int wrCnt = 0;
  int intWrCnt = 0;
  logic [31:0] lastIntWr = '0;

  always #2 clk = ~clk;

  byte_lane_bridge dut_i (
    .clk(clk), .rst_n(rst_n), .cpuMemEn(cpuMemEn), .cpuWe(cpuWe),
    .cpuAddr(cpuAddr), .cpuWData(cpuWData), .cpuRData(cpuRData),
    .cpuReady(cpuReady), .intEn(intEn), .intWe(intWe), .intAddr(intAddr),
    .intWData(intWData), .intRData(intRData), .extAddr(extAddr),
    .extWData(extWData), .extDataOe(extDataOe), .extRData(extRData),
    .extRdStrb(extRdStrb), .extWrStrb(extWrStrb)
  );

  function automatic logic [7:0] extPat(input logic [15:0] a, input logic [7:0] s);
    return (a[7:0] ^ a[15:8]) ^ (a[0] ? 8'hA5 : 8'h3C) ^ s;
  endfunction

  function automatic bit isExtAddr(input logic [15:0] a);
    if (a < 16'h2000) return 1'b0;
    if (a >= 16'h8000 && a < 16'h8400) return 1'b0;
    return 1'b1;
  endfunction

  assign extRData = extPat(extAddr, salt);
  assign intRData = intAddr ^ 16'hC3A5;

  always @(posedge clk) begin
    if (extWrStrb) begin
      if (wrCnt < 2) wrLog[wrCnt] <= {extAddr, extWData};
      wrCnt <= wrCnt + 1;
    end
    if (intEn && intWe) begin
      intWrCnt  <= intWrCnt + 1;
      lastIntWr <= {intAddr, intWData};
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checkCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Caller is just after a falling edge; returns just after a falling edge
  // with cpuMemEn still asserted (so the next call runs back to back).
  task automatic access(input logic [15:0] a, input logic we, input logic [15:0] wd,
                        input bit backToBack);
    bit ext = isExtAddr(a);
    int expCyc = ext ? EXT_CYC : 1;
    int cyc = 0;
    bit done = 1'b0;
    logic [15:0] rd = '0;
    logic [15:0] expRd;
    cpuAddr = a; cpuWe = we; cpuWData = wd; cpuMemEn = 1'b1;
    wrCnt = 0; intWrCnt = 0;
    expRd = ext ? {extPat({a[15:1], 1'b0}, salt), extPat({a[15:1], 1'b1}, salt)}
                : (a ^ 16'hC3A5);
    while (!done && cyc < 20) begin
      #1;
      if (cyc == 0)
        chk(cpuReady == !ext, backToBack ? "R4 R10" : "R4", "ready in first cycle",
            32'(cpuReady), 32'(!ext));
      if (ext) begin
        bit odd = (cyc >= W + 1);
        chk(extAddr == {a[15:1], odd}, "R6", "extAddr", 32'(extAddr), 32'({a[15:1], odd}));
        if (we) begin
          chk(extWData == (odd ? wd[7:0] : wd[15:8]) && extDataOe, "R8", "write byte",
              32'({extDataOe, extWData}), 32'({1'b1, odd ? wd[7:0] : wd[15:8]}));
          chk(extWrStrb == ((cyc % (W + 1)) == W) && !extRdStrb, "R8", "write pulse",
              32'({extRdStrb, extWrStrb}), 32'({1'b0, ((cyc % (W + 1)) == W)}));
        end else begin
          chk(extRdStrb && !extWrStrb && !extDataOe, "R9", "read strobe",
              32'({extDataOe, extRdStrb, extWrStrb}), 32'(3'b010));
        end
      end else begin
        chk(intEn && intAddr == a && intWData == wd && intWe == we &&
            !extRdStrb && !extWrStrb, "R3", "internal pass-through",
            32'({intEn, intWe, extRdStrb, extWrStrb}), 32'({1'b1, we, 2'b00}));
      end
      if (cpuReady) begin
        done = 1'b1;
        rd = cpuRData;
      end
      @(posedge clk); @(negedge clk);
      cyc++;
    end
    chk(cyc == expCyc, ext ? "R5" : "R3", "access length", 32'(cyc), 32'(expCyc));
    if (!we)
      chk(rd == expRd, ext ? "R7" : "R3", "read data", 32'(rd), 32'(expRd));
    else if (ext) begin
      chk(wrCnt == 2, "R8", "write pulse count", 32'(wrCnt), 32'd2);
      chk(wrLog[0] == {a[15:1], 1'b0, wd[15:8]} && wrLog[1] == {a[15:1], 1'b1, wd[7:0]},
          "R8", "byte order", 32'(wrLog[0]), 32'({a[15:1], 1'b0, wd[15:8]}));
    end else begin
      chk(intWrCnt == 1 && lastIntWr == {a, wd}, "R3", "internal write",
          lastIntWr, {a, wd});
    end
  endtask

  task automatic goIdle();
    cpuMemEn = 1'b0;
    #1;
    chk(cpuReady && !extRdStrb && !extWrStrb && !intEn, "R1", "idle outputs",
        32'({cpuReady, extRdStrb, extWrStrb, intEn}), 32'(4'b1000));
    @(posedge clk); @(negedge clk);
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      checkCnt++; failCnt++;
      $display("FAIL R5 watchdog expired actual=hung expected=done");
      $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(cpuReady && !extRdStrb && !extWrStrb && !extDataOe && !intEn, "R1", "reset state",
        32'({cpuReady, extRdStrb, extWrStrb, extDataOe, intEn}), 32'(5'b10000));
    @(negedge clk);

    // R2 decode boundaries and priority, isolated
    access(16'h1FFE, 1'b0, 16'h0, 1'b0); goIdle();   // R2 internal ROM edge
    access(16'h2000, 1'b0, 16'h0, 1'b0); goIdle();   // R2 unmatched -> external
    access(16'h83FE, 1'b0, 16'h0, 1'b0); goIdle();   // R2 scratch internal
    access(16'h8400, 1'b1, 16'hBEEF, 1'b0); goIdle(); // R2 priority -> external
    access(16'h6000, 1'b1, 16'h1234, 1'b0);
    access(16'h8002, 1'b0, 16'h0, 1'b1);             // R10 ext then internal
    access(16'h7FFE, 1'b0, 16'h0, 1'b1);             // R10 internal then ext
    access(16'hA001, 1'b0, 16'h0, 1'b1);             // R10 ext then ext
    goIdle();

    // Near-exhaustive sweep: every 1 KB block, three offsets, read and write
    for (int blk = 0; blk < 64; blk++) begin
      for (int off = 0; off < 3; off++) begin
        for (int we = 0; we < 2; we++) begin
          logic [15:0] a;
          a = 16'(blk * 1024) + ((off == 0) ? 16'h0000 : (off == 1) ? 16'h03FE : 16'h0155);
          salt = 8'(blk * 7 + off);
          access(a, we[0], 16'(a * 3 + 16'h5A0F), (blk % 5) != 0 || off != 0);
        end
        if (((blk + off) % 5) == 0) goIdle();
      end
    end
    goIdle();

    finished = 1'b1;
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end

endmodule